// File: doc/BRIEF.md
# Cache Line Eviction Sequencer

This block retires one cache line when a victim arriving from an upper cache finds its set full and the set's replacement candidate has to leave. When a trigger is accepted, the block copies the candidate's address, data and dirty flag into a single-entry holding buffer. One cycle later it issues a victim request to the directory slice that owns the address, and it pulses an invalidate for the line.

A Modified or Owned candidate produces a dirty victim request. An Exclusive or Shared candidate produces a clean one. The block then waits for memory to acknowledge the writeback. During a dirty eviction, an upper cache may write back the same line. The block acknowledges that writeback, discards the late data or stale notice, and sends a not-valid unblock to the directory. It still waits for memory's acknowledgement before it frees the buffer.

While the buffer is occupied, new replacement triggers are held off. The surrounding cache control retries them after the buffer is released.

Top module: `evict_seq`

## Requirements
- R1: After reset, the status state is 0 (idle), `stat_busy` is 0, `repl_ready` is 1, and no request, acknowledge or invalidate is driven.
- R2: A trigger accepted with line state Modified (4) or Owned (3) gives, one cycle later, a one-cycle request of kind 1 (dirty victim) carrying the trigger's address, data and dirty flag. It also gives a one-cycle invalidate for that address. The status becomes 1 (pending dirty).
- R3: A trigger accepted with line state Exclusive (2) or Shared (1) gives, one cycle later, a request of kind 2 (clean victim) with the captured address, data and dirty flag, plus the invalidate. The status becomes 2 (pending clean).
- R4: A trigger whose line state is Invalid (0), or any undefined code, produces no request and no invalidate, and the block stays idle.
- R5: While the status is not idle, `repl_ready` is 0 and a trigger produces no request and leaves the status unchanged.
- R6: A memory acknowledgement in state 1 or state 2 returns the status to 0, clears `stat_busy`, and raises `repl_ready`.
- R7: In state 1, an upper-cache writeback whose line address (the address above the block offset) matches the held line pulses `up_ack` one cycle later and moves the status to 3 (drop and wait). A writeback to a different line is ignored.
- R8: In state 3, a response (data or stale notice) for the held line gives, one cycle later, a request of kind 3 (not-valid unblock) for the held address, and the status returns to 1.
- R9: A memory acknowledgement in state 3 moves the status to 4 (drop). A response for the held line in state 4 gives a kind-3 unblock, and the status returns to 0.
- R10: A response arriving in state 1 is discarded: no request, and the status stays 1.
- R11: `dreq_dir` equals the SEL_BITS-wide field of the request address that starts at bit OFF_BITS (bits 7:6 by default).
- R12: In state 1, when a memory acknowledgement and a matching upper-cache writeback arrive in the same cycle, the acknowledgement wins. The status goes to 0 and `up_ack` stays 0.
- R13: In state 2, an upper-cache writeback to the held line is ignored: no `up_ack`, and the status stays 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| repl_valid | input | 1 | Replacement trigger for the set's candidate line |
| repl_ready | output | 1 | Buffer free; a trigger is taken this cycle |
| repl_line_st | input | 3 | Candidate state: 0 I, 1 S, 2 E, 3 O, 4 M |
| repl_addr | input | ADDR_W | Candidate line address |
| repl_data | input | DATA_W | Candidate line data |
| repl_dirty | input | 1 | Candidate dirty flag |
| upv_valid | input | 1 | Writeback request from an upper cache |
| upv_addr | input | ADDR_W | Address of that writeback |
| up_ack | output | 1 | Acknowledge returned to the upper cache |
| rsp_valid | input | 1 | Writeback data or stale notice arriving |
| rsp_addr | input | ADDR_W | Address of that response |
| mem_ack | input | 1 | Memory writeback acknowledgement for the held line |
| dreq_valid | output | 1 | Directory request strobe |
| dreq_kind | output | 2 | 1 dirty victim, 2 clean victim, 3 not-valid unblock |
| dreq_addr | output | ADDR_W | Request address (held line) |
| dreq_data | output | DATA_W | Victim data (meaningful for kinds 1 and 2) |
| dreq_dirty | output | 1 | Victim dirty flag (meaningful for kinds 1 and 2) |
| dreq_dir | output | DIR_W | Target directory slice |
| inv_valid | output | 1 | Invalidate strobe for the evicted line |
| inv_addr | output | ADDR_W | Address to invalidate |
| stat_state | output | 3 | 0 idle, 1 pending dirty, 2 pending clean, 3 drop and wait, 4 drop |
| stat_busy | output | 1 | Holding buffer occupied |

## Verification
The eviction is exercised with Modified, Owned, Shared and Invalid candidates. These show apart the dirty request, the clean request and the no-op, and addresses with different selector bits show that directory routing follows the address.

The race path is driven in order: a non-matching writeback, a matching writeback, data, a second writeback, the memory acknowledgement, and a stale notice. This pattern separates the drop-and-wait return to pending from the final drop to idle. Stray data, a busy-time trigger, a writeback during a clean eviction, and a simultaneous acknowledge plus writeback each check that an input is ignored or loses on priority.

// File: rtl/evq_pkg.sv
package evq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_PDIRTY = 3'd1,
    ST_PCLEAN = 3'd2,
    ST_DWAIT  = 3'd3,
    ST_DROP   = 3'd4
  } evq_st_e;

  typedef enum logic [1:0] {
    RK_NONE      = 2'd0,
    RK_DIRTY_VIC = 2'd1,
    RK_CLEAN_VIC = 2'd2,
    RK_UNBLK_NV  = 2'd3
  } evq_rk_e;

  localparam logic [2:0] LN_INV = 3'd0;
  localparam logic [2:0] LN_SHR = 3'd1;
  localparam logic [2:0] LN_EXC = 3'd2;
  localparam logic [2:0] LN_OWN = 3'd3;
  localparam logic [2:0] LN_MOD = 3'd4;
endpackage

// File: rtl/evq_hold_buf.sv
module evq_hold_buf #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap,
  input  logic              rel,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_dirty,
  output logic [ADDR_W-1:0] h_addr,
  output logic [DATA_W-1:0] h_data,
  output logic              h_dirty,
  output logic              h_vld
);
  // contents kept after release so a final unblock can still name the line
  always_ff @(posedge clk) begin
    if (cap) begin
      h_addr  <= in_addr;
      h_data  <= in_data;
      h_dirty <= in_dirty;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)      h_vld <= 1'b0;
    else if (cap) h_vld <= 1'b1;
    else if (rel) h_vld <= 1'b0;
  end

  // R5
  cap_when_free_chk: assert property (@(posedge clk) disable iff (rst)
    cap |-> !h_vld);
endmodule

// File: rtl/evq_dir_map.sv
module evq_dir_map #(
  parameter int ADDR_W   = 32,
  parameter int OFF_BITS = 6,
  parameter int SEL_BITS = 2,
  localparam int DIR_W   = (SEL_BITS > 0) ? SEL_BITS : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [DIR_W-1:0]  dir
);
  generate
    if (SEL_BITS > 0) begin : g_sel
      assign dir = addr[OFF_BITS +: SEL_BITS];
    end else begin : g_single
      assign dir = '0;
    end
  endgenerate
endmodule

// File: rtl/evq_ctrl.sv
module evq_ctrl
  import evq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       repl_valid,
  input  logic [2:0] line_st,
  input  logic       mem_ack,
  input  logic       upv_hit,
  input  logic       rsp_hit,
  output evq_st_e    st,
  output logic       ready,
  output logic       cap,
  output logic       rel,
  output evq_rk_e    kind_q,
  output logic       upack_q,
  output logic       inv_q
);
  evq_st_e nxt;
  evq_rk_e kind_d;
  logic    upack_d;
  logic    dirty_line, clean_line;

  assign ready      = (st == ST_IDLE);
  assign dirty_line = (line_st == LN_MOD) || (line_st == LN_OWN);
  assign clean_line = (line_st == LN_EXC) || (line_st == LN_SHR);

  always_comb begin
    nxt     = st;
    kind_d  = RK_NONE;
    upack_d = 1'b0;
    cap     = 1'b0;
    case (st)
      ST_IDLE: begin
        if (repl_valid && dirty_line) begin
          nxt = ST_PDIRTY; kind_d = RK_DIRTY_VIC; cap = 1'b1;
        end else if (repl_valid && clean_line) begin
          nxt = ST_PCLEAN; kind_d = RK_CLEAN_VIC; cap = 1'b1;
        end
      end
      ST_PDIRTY: begin
        if (mem_ack)      nxt = ST_IDLE;
        else if (upv_hit) begin nxt = ST_DWAIT; upack_d = 1'b1; end
      end
      ST_PCLEAN: begin
        if (mem_ack) nxt = ST_IDLE;
      end
      ST_DWAIT: begin
        if (mem_ack)      nxt = ST_DROP;
        else if (rsp_hit) begin nxt = ST_PDIRTY; kind_d = RK_UNBLK_NV; end
      end
      ST_DROP: begin
        if (rsp_hit) begin nxt = ST_IDLE; kind_d = RK_UNBLK_NV; end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  assign rel = (st != ST_IDLE) && (nxt == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      kind_q  <= RK_NONE;
      upack_q <= 1'b0;
      inv_q   <= 1'b0;
    end else begin
      st      <= nxt;
      kind_q  <= kind_d;
      upack_q <= upack_d;
      inv_q   <= cap;
    end
  end

  // R10
  stray_data_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_PDIRTY && rsp_hit && !mem_ack && !upv_hit) |=>
      (st == ST_PDIRTY && kind_q == RK_NONE));

  // R12
  ack_beats_wb_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_PDIRTY && mem_ack && upv_hit) |=> (st == ST_IDLE && !upack_q));

  // R6
  clean_ack_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_PCLEAN && mem_ack) |=> (st == ST_IDLE));
endmodule

// File: rtl/evict_seq.sv
module evict_seq
  import evq_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 64,
  parameter int OFF_BITS = 6,
  parameter int SEL_BITS = 2,
  localparam int DIR_W   = (SEL_BITS > 0) ? SEL_BITS : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              repl_valid,
  output logic              repl_ready,
  input  logic [2:0]        repl_line_st,
  input  logic [ADDR_W-1:0] repl_addr,
  input  logic [DATA_W-1:0] repl_data,
  input  logic              repl_dirty,
  input  logic              upv_valid,
  input  logic [ADDR_W-1:0] upv_addr,
  output logic              up_ack,
  input  logic              rsp_valid,
  input  logic [ADDR_W-1:0] rsp_addr,
  input  logic              mem_ack,
  output logic              dreq_valid,
  output logic [1:0]        dreq_kind,
  output logic [ADDR_W-1:0] dreq_addr,
  output logic [DATA_W-1:0] dreq_data,
  output logic              dreq_dirty,
  output logic [DIR_W-1:0]  dreq_dir,
  output logic              inv_valid,
  output logic [ADDR_W-1:0] inv_addr,
  output logic [2:0]        stat_state,
  output logic              stat_busy
);
  localparam logic [ADDR_W-1:0] LINE_MASK = ~((ADDR_W'(1) << OFF_BITS) - ADDR_W'(1));

  evq_st_e           st;
  evq_rk_e           kind_q;
  logic              cap, rel, upack_q, inv_q, ready;
  logic [ADDR_W-1:0] h_addr;
  logic [DATA_W-1:0] h_data;
  logic              h_dirty, h_vld;
  logic              upv_hit, rsp_hit;

  assign upv_hit = upv_valid && (((upv_addr ^ h_addr) & LINE_MASK) == '0);
  assign rsp_hit = rsp_valid && (((rsp_addr ^ h_addr) & LINE_MASK) == '0);

  evq_ctrl u_ctrl (
    .clk(clk), .rst(rst), .repl_valid(repl_valid), .line_st(repl_line_st),
    .mem_ack(mem_ack), .upv_hit(upv_hit), .rsp_hit(rsp_hit),
    .st(st), .ready(ready), .cap(cap), .rel(rel),
    .kind_q(kind_q), .upack_q(upack_q), .inv_q(inv_q)
  );

  evq_hold_buf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst(rst), .cap(cap), .rel(rel),
    .in_addr(repl_addr), .in_data(repl_data), .in_dirty(repl_dirty),
    .h_addr(h_addr), .h_data(h_data), .h_dirty(h_dirty), .h_vld(h_vld)
  );

  evq_dir_map #(.ADDR_W(ADDR_W), .OFF_BITS(OFF_BITS), .SEL_BITS(SEL_BITS)) u_dir (
    .addr(h_addr), .dir(dreq_dir)
  );

  assign repl_ready = ready;
  assign up_ack     = upack_q;
  assign dreq_valid = (kind_q != RK_NONE);
  assign dreq_kind  = kind_q;
  assign dreq_addr  = h_addr;
  assign dreq_data  = h_data;
  assign dreq_dirty = h_dirty;
  assign inv_valid  = inv_q;
  assign inv_addr   = h_addr;
  assign stat_state = st;
  assign stat_busy  = h_vld;

  // R2 R3
  victim_from_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (dreq_valid && (kind_q == RK_DIRTY_VIC || kind_q == RK_CLEAN_VIC)) |->
      ($past(st) == ST_IDLE && inv_valid));

  // R7
  up_ack_enters_drop_chk: assert property (@(posedge clk) disable iff (rst)
    up_ack |-> (st == ST_DWAIT && $past(st) == ST_PDIRTY));

  // R8 R9
  unblock_from_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (dreq_valid && kind_q == RK_UNBLK_NV) |->
      ($past(st) == ST_DWAIT || $past(st) == ST_DROP));

  // R6
  busy_matches_state_chk: assert property (@(posedge clk) disable iff (rst)
    stat_busy == (st != ST_IDLE));
endmodule

// File: tb/evict_seq_test.sv
`timescale 1ns/1ps
module evict_seq_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        repl_valid, repl_ready, repl_dirty;
  logic [2:0]  repl_line_st;
  logic [31:0] repl_addr, upv_addr, rsp_addr, dreq_addr, inv_addr;
  logic [63:0] repl_data, dreq_data;
  logic        upv_valid, up_ack, rsp_valid, mem_ack;
  logic        dreq_valid, dreq_dirty, inv_valid, stat_busy;
  logic [1:0]  dreq_kind, dreq_dir;
  logic [2:0]  stat_state;
  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  evict_seq uut (
    .clk(clk), .rst(rst), .repl_valid(repl_valid), .repl_ready(repl_ready),
    .repl_line_st(repl_line_st), .repl_addr(repl_addr), .repl_data(repl_data),
    .repl_dirty(repl_dirty), .upv_valid(upv_valid), .upv_addr(upv_addr),
    .up_ack(up_ack), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .mem_ack(mem_ack),
    .dreq_valid(dreq_valid), .dreq_kind(dreq_kind), .dreq_addr(dreq_addr),
    .dreq_data(dreq_data), .dreq_dirty(dreq_dirty), .dreq_dir(dreq_dir),
    .inv_valid(inv_valid), .inv_addr(inv_addr), .stat_state(stat_state),
    .stat_busy(stat_busy)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] dir_of(input logic [31:0] a);
    return a[7:6];
  endfunction

  task automatic trig(input logic [2:0] ls, input logic [31:0] a, input logic [63:0] d, input logic dy);
    repl_valid = 1'b1; repl_line_st = ls; repl_addr = a; repl_data = d; repl_dirty = dy;
    @(negedge clk);
    repl_valid = 1'b0;
  endtask

  task automatic upv(input logic [31:0] a);
    upv_valid = 1'b1; upv_addr = a;
    @(negedge clk);
    upv_valid = 1'b0;
  endtask

  task automatic rsp(input logic [31:0] a);
    rsp_valid = 1'b1; rsp_addr = a;
    @(negedge clk);
    rsp_valid = 1'b0;
  endtask

  task automatic ack();
    mem_ack = 1'b1;
    @(negedge clk);
    mem_ack = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 state", stat_state, 0);
    chk("R1 busy", stat_busy, 0);
    chk("R1 ready", repl_ready, 1);
    chk("R1 dreq", dreq_valid, 0);
    chk("R1 inv", inv_valid, 0);
    chk("R1 ack", up_ack, 0);
  endtask

  task automatic t_modified();
    logic [31:0] a = 32'h0000_1280;
    trig(3'd4, a, 64'hDEAD_BEEF_0123_4567, 1'b1);
    chk("R2 valid", dreq_valid, 1);
    chk("R2 kind", dreq_kind, 1);
    chk("R2 addr", dreq_addr, a);
    chk("R2 data", dreq_data, 64'hDEAD_BEEF_0123_4567);
    chk("R2 dirty", dreq_dirty, 1);
    chk("R2 inv", inv_valid, 1);
    chk("R2 inv addr", inv_addr, a);
    chk("R2 state", stat_state, 1);
    chk("R11 dir", dreq_dir, dir_of(a));
    @(negedge clk);
    chk("R2 one-shot", dreq_valid, 0);
    chk("R5 ready low", repl_ready, 0);
    trig(3'd4, 32'h0000_3000, 64'h1, 1'b1);
    chk("R5 no req", dreq_valid, 0);
    chk("R5 state", stat_state, 1);
    rsp(a);
    chk("R10 no req", dreq_valid, 0);
    chk("R10 state", stat_state, 1);
    ack();
    chk("R6 state", stat_state, 0);
    chk("R6 busy", stat_busy, 0);
    chk("R6 ready", repl_ready, 1);
  endtask

  task automatic t_shared();
    logic [31:0] a = 32'h0000_40C0;
    trig(3'd1, a, 64'h5555_AAAA, 1'b0);
    chk("R3 kind", dreq_kind, 2);
    chk("R3 valid", dreq_valid, 1);
    chk("R3 addr", dreq_addr, a);
    chk("R3 data", dreq_data, 64'h5555_AAAA);
    chk("R3 dirty", dreq_dirty, 0);
    chk("R3 inv", inv_valid, 1);
    chk("R3 state", stat_state, 2);
    chk("R11 dir", dreq_dir, dir_of(a));
    upv(a);
    chk("R13 ack", up_ack, 0);
    chk("R13 state", stat_state, 2);
    ack();
    chk("R6 clean state", stat_state, 0);
  endtask

  task automatic t_invalid();
    trig(3'd0, 32'h0000_5000, 64'h7, 1'b0);
    chk("R4 req", dreq_valid, 0);
    chk("R4 inv", inv_valid, 0);
    chk("R4 state", stat_state, 0);
  endtask

  task automatic t_race();
    logic [31:0] a = 32'h0000_2040;
    trig(3'd3, a, 64'h0BAD_F00D, 1'b1);
    chk("R2 owned kind", dreq_kind, 1);
    chk("R11 dir", dreq_dir, dir_of(a));
    upv(32'h0000_9040);
    chk("R7 other line ack", up_ack, 0);
    chk("R7 other line state", stat_state, 1);
    upv(a + 32'h8);
    chk("R7 ack", up_ack, 1);
    chk("R7 state", stat_state, 3);
    rsp(a);
    chk("R8 req", dreq_valid, 1);
    chk("R8 kind", dreq_kind, 3);
    chk("R8 addr", dreq_addr, a);
    chk("R8 state", stat_state, 1);
    upv(a);
    chk("R7 again", stat_state, 3);
    ack();
    chk("R9 drop", stat_state, 4);
    chk("R9 no req", dreq_valid, 0);
    rsp(a);
    chk("R9 kind", dreq_kind, 3);
    chk("R9 valid", dreq_valid, 1);
    chk("R9 state", stat_state, 0);
    chk("R9 ready", repl_ready, 1);
  endtask

  task automatic t_priority();
    logic [31:0] a = 32'h0000_7100;
    trig(3'd4, a, 64'h42, 1'b1);
    upv_valid = 1'b1; upv_addr = a; mem_ack = 1'b1;
    @(negedge clk);
    upv_valid = 1'b0; mem_ack = 1'b0;
    chk("R12 state", stat_state, 0);
    chk("R12 ack", up_ack, 0);
  endtask

  initial begin
    rst = 1'b1; repl_valid = 0; repl_line_st = 0; repl_addr = 0; repl_data = 0;
    repl_dirty = 0; upv_valid = 0; upv_addr = 0; rsp_valid = 0; rsp_addr = 0; mem_ack = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_modified();
    t_shared();
    t_invalid();
    t_race();
    t_priority();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule